// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Channel

This block is one compare channel that watches a free-running timer count and drives a single output pin from it. Each channel picks one of two external timebases. It compares the chosen count against a primary and a secondary compare value, and shapes the pin according to a 3-bit operating mode. The modes are: off, set on match, clear on match, toggle on match, one dual-match pulse, repeated dual-match pulses, and pulse-width modulation with or without a fault shutdown.

Software reaches the channel through a small write port with three word addresses: control, primary compare and secondary compare. In the PWM modes the timer's period-match strobe starts each high phase, and the primary duty register ends it. The duty register is reloaded from the secondary compare value only at period boundaries, so a duty change never produces a glitched period. A one-cycle interrupt pulse marks each compare, pulse-end, PWM period or fault event. An interrupt controller outside the block can count or latch these pulses.

Top module: `ocmp_channel`

## Requirements
- R1: After synchronous reset, oc_pin, oc_oe and oc_irq are 0, and the mode is 000 with timebase 0. Both compare registers are 0.
- R2: A write with wr_en high takes effect from the next clock. Address 0 is control, with mode in wr_data[2:0] and timebase select in wr_data[3]. Address 1 is the primary value and address 2 is the secondary value. A control write clears the output latch, the fault latch and the single-pulse lock, reloads duty from the secondary value, and raises no interrupt in that cycle.
- R3: Timebase select 0 uses the A count and A period strobe. Select 1 uses the B count and B period strobe.
- R4: Mode 000 holds oc_pin and oc_oe low and raises no interrupt.
- R5: Modes 001, 010 and 011 set, clear or toggle the output when count equals the primary value. The pin change and a one-cycle oc_irq both appear on the clock edge that ends the matching cycle.
- R6: Mode 101 drives the output high when count equals primary. While the output is high, a count equal to secondary drives it low and pulses oc_irq.
- R7: Mode 100 behaves like R6 for one pulse only. After that falling edge the output stays low until the control register is written again.
- R8: Modes 110 and 111 drive the output high and pulse oc_irq on the selected period strobe, loading duty from the secondary value. In a cycle without a strobe, a count equal to duty drives the output low.
- R9: A secondary write in a PWM mode does not alter the current period's falling point. It takes effect only after the next period strobe.
- R10: In mode 111, a low fault_n forces oc_pin low in the same cycle, without waiting for a clock. It latches a fault that holds the output low and suppresses PWM events until the next control write, and it pulses oc_irq once on entry. Mode 110 ignores fault_n.
- R11: oc_oe is high in every mode other than 000, and oc_pin is never high while oc_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a_cnt | input | W | Count of timebase A |
| tmr_a_pm | input | 1 | Period-match strobe of timebase A |
| tmr_b_cnt | input | W | Count of timebase B |
| tmr_b_pm | input | 1 | Period-match strobe of timebase B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address (0 control, 1 primary, 2 secondary) |
| wr_data | input | W | Register write data |
| fault_n | input | 1 | Active-low fault input, used in mode 111 |
| oc_pin | output | 1 | Compare output pin |
| oc_oe | output | 1 | Output enable of the pin |
| oc_irq | output | 1 | One-cycle interrupt event pulse |

## Verification
The bench builds the channel with its default 16-bit count width. It drives the two timebases from short bench counters with unequal periods of 10 and 14 cycles, so every mode sees many matches, period strobes and wraps in a few hundred cycles. Because the periods differ, a primary value above the shorter period distinguishes the two timebases. A behavioural model checks pin, enable and interrupt on every clock. The run covers directed mode sequences, a mid-period duty rewrite, a fault pulse observed between clock edges, and a long phase of random register writes and fault activity.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'b000,
        MODE_SET    = 3'b001,
        MODE_CLR    = 3'b010,
        MODE_TGL    = 3'b011,
        MODE_PULSE1 = 3'b100,
        MODE_PULSEN = 3'b101,
        MODE_PWM    = 3'b110,
        MODE_PWMF   = 3'b111
    } oc_mode_e;

    typedef struct packed {
        logic     tb_sel;
        oc_mode_e mode;
    } oc_cfg_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PRI  = 2'd1;
    localparam logic [1:0] ADDR_SEC  = 2'd2;

    localparam int NUM_REFS = 3;
    localparam int REF_PRI  = 0;
    localparam int REF_SEC  = 1;
    localparam int REF_DUTY = 2;

    function automatic logic mode_is_pwm(oc_mode_e m);
        return (m == MODE_PWM) || (m == MODE_PWMF);
    endfunction

    function automatic oc_cfg_t cfg_from_bits(logic [3:0] b);
        oc_cfg_t c;
        c.tb_sel = b[3];
        c.mode   = oc_mode_e'(b[2:0]);
        return c;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output oc_cfg_t      cfg,
    output logic [W-1:0] pri_val,
    output logic [W-1:0] sec_val,
    output logic         ctrl_wr
);

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{tb_sel: 1'b0, mode: MODE_OFF};
            pri_val <= '0;
            sec_val <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: cfg     <= cfg_from_bits(wr_data[3:0]);
                ADDR_PRI:  pri_val <= wr_data;
                ADDR_SEC:  sec_val <= wr_data;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/ocmp_tbsel.sv
module ocmp_tbsel
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         tb_sel,
    input  logic [W-1:0] a_cnt,
    input  logic         a_pm,
    input  logic [W-1:0] b_cnt,
    input  logic         b_pm,
    input  logic [W-1:0] pri_val,
    input  logic [W-1:0] sec_val,
    input  logic [W-1:0] duty_val,
    output logic         hit_pri,
    output logic         hit_sec,
    output logic         hit_duty,
    output logic         period_hit
);

    logic [W-1:0] cnt;
    logic [W-1:0] refs [NUM_REFS];
    logic [NUM_REFS-1:0] hits;

    assign cnt        = tb_sel ? b_cnt : a_cnt;
    assign period_hit = tb_sel ? b_pm  : a_pm;

    assign refs[REF_PRI]  = pri_val;
    assign refs[REF_SEC]  = sec_val;
    assign refs[REF_DUTY] = duty_val;

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_cmp
        assign hits[i] = (cnt == refs[i]);
    end

    assign hit_pri  = hits[REF_PRI];
    assign hit_sec  = hits[REF_SEC];
    assign hit_duty = hits[REF_DUTY];

endmodule

// File: rtl/ocmp_outlogic.sv
module ocmp_outlogic
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  oc_cfg_t      cfg,
    input  logic         ctrl_wr,
    input  logic [W-1:0] sec_val,
    input  logic         hit_pri,
    input  logic         hit_sec,
    input  logic         hit_duty,
    input  logic         period_hit,
    input  logic         fault_n,
    output logic         q,
    output logic         irq,
    output logic [W-1:0] duty_val,
    output logic         fault_act
);

    logic flt;
    logic done;

    assign fault_act = (cfg.mode == MODE_PWMF) && (flt || !fault_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= 1'b0;
            irq      <= 1'b0;
            duty_val <= '0;
            flt      <= 1'b0;
            done     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (ctrl_wr) begin
                q        <= 1'b0;
                flt      <= 1'b0;
                done     <= 1'b0;
                duty_val <= sec_val;
            end else begin
                unique case (cfg.mode)
                    MODE_OFF: q <= 1'b0;
                    MODE_SET: if (hit_pri) begin
                        q   <= 1'b1;
                        irq <= 1'b1;
                    end
                    MODE_CLR: if (hit_pri) begin
                        q   <= 1'b0;
                        irq <= 1'b1;
                    end
                    MODE_TGL: if (hit_pri) begin
                        q   <= ~q;
                        irq <= 1'b1;
                    end
                    MODE_PULSE1: begin
                        if (q && hit_sec) begin
                            q    <= 1'b0;
                            done <= 1'b1;
                            irq  <= 1'b1;
                        end else if (!done && hit_pri) begin
                            q <= 1'b1;
                        end
                    end
                    MODE_PULSEN: begin
                        if (q && hit_sec) begin
                            q   <= 1'b0;
                            irq <= 1'b1;
                        end else if (hit_pri) begin
                            q <= 1'b1;
                        end
                    end
                    MODE_PWM, MODE_PWMF: begin
                        if (cfg.mode == MODE_PWMF && flt) begin
                            q <= 1'b0;
                        end else if (cfg.mode == MODE_PWMF && !fault_n) begin
                            flt <= 1'b1;
                            q   <= 1'b0;
                            irq <= 1'b1;
                        end else if (period_hit) begin
                            q        <= 1'b1;
                            duty_val <= sec_val;
                            irq      <= 1'b1;
                        end else if (hit_duty) begin
                            q <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    p_off_low_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_OFF && !ctrl_wr) |=> !q);

    p_set_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_SET && q && !ctrl_wr) |=> q);

    p_clr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_CLR && !q && !ctrl_wr) |=> !q);

    p_one_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_PULSE1 && done && !ctrl_wr) |=> (done && !q));

    p_duty_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_is_pwm(cfg.mode) && !period_hit && !ctrl_wr) |=> $stable(duty_val));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_PWMF && flt && !ctrl_wr) |=> (flt && !q && !irq));

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tmr_a_cnt,
    input  logic         tmr_a_pm,
    input  logic [W-1:0] tmr_b_cnt,
    input  logic         tmr_b_pm,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         fault_n,
    output logic         oc_pin,
    output logic         oc_oe,
    output logic         oc_irq
);

    oc_cfg_t      cfg;
    logic [W-1:0] pri_val;
    logic [W-1:0] sec_val;
    logic [W-1:0] duty_val;
    logic         ctrl_wr;
    logic         hit_pri;
    logic         hit_sec;
    logic         hit_duty;
    logic         period_hit;
    logic         q;
    logic         fault_act;

    ocmp_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .pri_val (pri_val),
        .sec_val (sec_val),
        .ctrl_wr (ctrl_wr)
    );

    ocmp_tbsel #(.W(W)) u_tbsel (
        .tb_sel     (cfg.tb_sel),
        .a_cnt      (tmr_a_cnt),
        .a_pm       (tmr_a_pm),
        .b_cnt      (tmr_b_cnt),
        .b_pm       (tmr_b_pm),
        .pri_val    (pri_val),
        .sec_val    (sec_val),
        .duty_val   (duty_val),
        .hit_pri    (hit_pri),
        .hit_sec    (hit_sec),
        .hit_duty   (hit_duty),
        .period_hit (period_hit)
    );

    ocmp_outlogic #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .ctrl_wr    (ctrl_wr),
        .sec_val    (sec_val),
        .hit_pri    (hit_pri),
        .hit_sec    (hit_sec),
        .hit_duty   (hit_duty),
        .period_hit (period_hit),
        .fault_n    (fault_n),
        .q          (q),
        .irq        (oc_irq),
        .duty_val   (duty_val),
        .fault_act  (fault_act)
    );

    assign oc_oe  = (cfg.mode != MODE_OFF);
    assign oc_pin = q && oc_oe && !fault_act;

    p_ctrl_clears_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (!q && !oc_irq));

endmodule

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;
    localparam int W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1;
    logic [W-1:0] a_cnt = '0, b_cnt = '0;
    logic         a_pm = 1'b0, b_pm = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         fault_n = 1'b1;
    wire          oc_pin, oc_oe, oc_irq;

    int per_a = 9, per_b = 13;
    int a_int = 0, b_int = 0;
    int checks = 0, fails = 0;
    string phase = "R1";
    bit cmp_on = 0;

    int m_mode = 0, m_sel = 0, m_pri = 0, m_sec = 0, m_duty = 0;
    bit m_q = 0, m_flt = 0, m_done = 0, m_irq = 0;

    ocmp_channel #(.W(W)) i_ocmp_channel (
        .clk(clk), .rst(rst),
        .tmr_a_cnt(a_cnt), .tmr_a_pm(a_pm),
        .tmr_b_cnt(b_cnt), .tmr_b_pm(b_pm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_n(fault_n),
        .oc_pin(oc_pin), .oc_oe(oc_oe), .oc_irq(oc_irq)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // bench timebases: count 0..period, strobe while at period
    always @(negedge clk) begin
        #2;
        a_int = (a_int >= per_a) ? 0 : a_int + 1;
        b_int = (b_int >= per_b) ? 0 : b_int + 1;
        a_cnt = a_int[W-1:0];
        b_cnt = b_int[W-1:0];
        a_pm  = (a_int == per_a);
        b_pm  = (b_int == per_b);
    end

    // behavioural reference model
    always @(posedge clk) begin
        int cnt;
        bit pm, hp, hs, hd, ev;
        if (rst) begin
            m_mode = 0; m_sel = 0; m_pri = 0; m_sec = 0; m_duty = 0;
            m_q = 0; m_flt = 0; m_done = 0; m_irq = 0;
        end else begin
            cnt = m_sel ? b_int : a_int;
            pm  = m_sel ? b_pm : a_pm;
            hp = (cnt == m_pri); hs = (cnt == m_sec); hd = (cnt == m_duty);
            ev = 0;
            if (wr_en && wr_addr == 2'd0) begin
                m_mode = int'(wr_data[2:0]); m_sel = int'(wr_data[3]);
                m_q = 0; m_flt = 0; m_done = 0; m_duty = m_sec;
            end else begin
                case (m_mode)
                    0: m_q = 0;
                    1: if (hp) begin m_q = 1; ev = 1; end
                    2: if (hp) begin m_q = 0; ev = 1; end
                    3: if (hp) begin m_q = !m_q; ev = 1; end
                    4: if (m_q && hs) begin m_q = 0; m_done = 1; ev = 1; end
                       else if (!m_done && hp) m_q = 1;
                    5: if (m_q && hs) begin m_q = 0; ev = 1; end
                       else if (hp) m_q = 1;
                    default: begin
                        if (m_mode == 7 && m_flt) m_q = 0;
                        else if (m_mode == 7 && !fault_n) begin m_flt = 1; m_q = 0; ev = 1; end
                        else if (pm) begin m_q = 1; m_duty = m_sec; ev = 1; end
                        else if (hd) m_q = 0;
                    end
                endcase
            end
            if (wr_en && wr_addr == 2'd1) m_pri = int'(wr_data);
            if (wr_en && wr_addr == 2'd2) m_sec = int'(wr_data);
            m_irq = ev;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit e_oe, e_pin;
        if (cmp_on) begin
            e_oe  = (m_mode != 0);
            e_pin = m_q && e_oe && !(m_mode == 7 && (m_flt || !fault_n));
            chk(phase, "oc_pin", oc_pin, e_pin);
            chk(phase, "oc_oe", oc_oe, e_oe);
            chk(phase, "oc_irq", oc_irq, m_irq);
            if (oc_pin && !oc_oe) chk("R11", "pin without enable", 1'b1, 1'b0);
        end
    end

    task automatic wr(input logic [1:0] adr, input int val);
        @(negedge clk); #2;
        wr_en = 1'b1; wr_addr = adr; wr_data = val[W-1:0];
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic ctrl(input int sel, input int mode);
        wr(2'd0, sel * 8 + mode);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_rises(input int n, output int rises);
        logic prev;
        rises = 0;
        @(negedge clk); prev = oc_pin;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (oc_pin && !prev) rises++;
            prev = oc_pin;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        cmp_on = 1;
        phase = "R1";
        chk("R1", "pin after reset", oc_pin, 1'b0);
        chk("R1", "oe after reset", oc_oe, 1'b0);
        chk("R1", "irq after reset", oc_irq, 1'b0);

        phase = "R4";
        wr(2'd1, 3); wr(2'd2, 7);
        run(25);
        chk("R4", "oe in mode 000", oc_oe, 1'b0);
        chk("R4", "pin in mode 000", oc_pin, 1'b0);

        phase = "R5";
        ctrl(0, 1); run(15);
        chk("R5", "set mode pin", oc_pin, 1'b1);
        chk("R11", "oe in mode 001", oc_oe, 1'b1);
        phase = "R2";
        ctrl(0, 1);
        chk("R2", "control write clears latch", oc_pin, 1'b0);
        run(15);
        phase = "R5";
        ctrl(0, 2); run(25);
        chk("R5", "clear mode pin", oc_pin, 1'b0);
        ctrl(0, 3); run(40);

        phase = "R3";
        wr(2'd1, 11);
        ctrl(0, 1); run(30);
        chk("R3", "timebase A never reaches 11", oc_pin, 1'b0);
        ctrl(1, 1); run(30);
        chk("R3", "timebase B reaches 11", oc_pin, 1'b1);
        ctrl(1, 3); run(40);

        phase = "R6";
        wr(2'd1, 2); wr(2'd2, 6);
        ctrl(0, 5);
        run_rises(60, r);
        chk("R6", "repeated pulses", (r >= 5), 1'b1);

        phase = "R7";
        ctrl(0, 4);
        run_rises(60, r);
        chk("R7", "exactly one pulse", (r == 1), 1'b1);
        chk("R7", "low after pulse", oc_pin, 1'b0);
        ctrl(1, 4); run(40);

        phase = "R8";
        wr(2'd2, 4);
        ctrl(0, 6);
        run_rises(60, r);
        chk("R8", "one high phase per period", (r >= 5), 1'b1);

        phase = "R9";
        run(3);
        wr(2'd2, 8); run(30);
        wr(2'd2, 1); run(30);

        phase = "R10";
        @(negedge clk); #2 fault_n = 1'b0;
        run(5);
        @(negedge clk); #2 fault_n = 1'b1;
        run(10);
        ctrl(0, 7); run(12);
        @(negedge clk); #2 fault_n = 1'b0;
        #1 chk("R10", "fault forces pin low at once", oc_pin, 1'b0);
        @(negedge clk); #2 fault_n = 1'b1;
        run(30);
        chk("R10", "fault stays latched", oc_pin, 1'b0);
        ctrl(1, 7); run(30);

        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k == 0) ctrl($urandom_range(0, 1), $urandom_range(0, 7));
            else if (k == 1) wr(2'd1, $urandom_range(0, 14));
            else if (k == 2) wr(2'd2, $urandom_range(0, 14));
            else if (k == 3) wr(2'd3, $urandom_range(0, 14));
            else begin
                @(negedge clk); #2 fault_n = ($urandom_range(0, 15) != 0);
            end
        end
        fault_n = 1'b1;
        run(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule